// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block supervises three half-bridge power stages. Each stage has a high-side and a low-side switch. Analog comparators sit outside the block and present their results as digital flags: overcurrent for each switch, underload for each output, supply undervoltage, supply overvoltage, temperature prewarning and thermal shutdown. From these flags and a 16-bit control word, the block drives one gate-enable line per switch and maintains a 16-bit diagnosis word.

Overcurrent and underload flags are qualified by persistence timers before they act. The timer lengths are given in system clock cycles. Overcurrent removes only the switch that failed. Supply and thermal faults remove every switch. Two control bits can mask the overcurrent reaction and the overvoltage reaction. A supply fault does not erase the stored control word, so switching resumes once the supply recovers. Every diagnosis flag is sticky, and so is every overcurrent cut-off. Both are released by a control write that carries the clear bit.

The control interface is a plain one-cycle write strobe with no back-pressure. A word on `wr_data` is taken on every clock edge where `wr_en` is high. The block cannot refuse a write, so the control side never waits.

Top module: `hb_fault_supervisor`

## Requirements
- R1: During reset and on the first cycle after it, `gate_en` is all zero and `diag` is all zero.
- R2: A write stores control bits 6:1 as switch requests, in the order low-side 1, high-side 1, low-side 2, high-side 2, low-side 3, high-side 3. With no fault present, `gate_en[5:0]` equals those requests from the cycle after the write.
- R3: When control bit 13 is 1 and a switch's overcurrent flag stays high for OC_DLY consecutive clock edges, only that switch's gate enable drops, one edge later, and it stays low after the flag falls. A run shorter than OC_DLY edges has no effect, because the timer restarts when the flag drops.
- R4: When control bit 13 is 0, a qualified overcurrent leaves every gate enable unchanged.
- R5: Diagnosis bit 13 sets one edge after any switch's overcurrent qualifies, whatever the value of control bit 13.
- R6: A temperature prewarning sets diagnosis bit 0 two edges after the flag is seen. It does not affect any gate enable.
- R7: Undervoltage forces all gate enables low from the edge after it is seen. Overvoltage does the same only when control bit 15 is 1. Either supply fault sets diagnosis bit 15 one edge later. The switch requests survive, so the gates return when the fault clears.
- R8: When an output's underload flag stays high for UL_DLY consecutive edges, diagnosis bit 14 sets one edge later. Shorter runs are forgotten.
- R9: Diagnosis bits 6:1 mirror the present `gate_en[5:0]`. Bits 12:7 read zero.
- R10: Thermal shutdown forces all gate enables low from the edge after it is seen, for as long as it is present.
- R11: A write with bit 0 equal to 1 clears diagnosis bits 15, 14, 13 and 0, and every latched overcurrent cut-off, at that edge. A fault that is still qualified sets its flag again on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe, one word per high cycle |
| wr_data | input | 16 | Control word |
| oc_raw | input | 6 | Overcurrent flags, one per switch, in the order of `gate_en` |
| ul_raw | input | 3 | Underload flags, one per output |
| uv_raw | input | 1 | Supply undervoltage flag |
| ov_raw | input | 1 | Supply overvoltage flag |
| tw_raw | input | 1 | Temperature prewarning flag |
| tsd_raw | input | 1 | Thermal shutdown flag |
| gate_en | output | 6 | Gate enables: LS1, HS1, LS2, HS2, LS3, HS3 |
| diag | output | 16 | Diagnosis word |

## Verification
The hardest case to reach is a qualified overcurrent that is still present when a clear write arrives. The cut-off must lift for exactly one cycle and then latch again. This only happens when an overcurrent run survives a full persistence window and the clear lands while the flag is still high. The directed part of the bench builds this case. It shortens the timers through parameters and holds the flag across the write. The random part keeps each raw flag in its state for many cycles at a time, so that long runs, flag drops just short of the window and clear writes during faults all occur often.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;
  localparam int NBRIDGE = 3;
  localparam int NSW     = 2 * NBRIDGE;
  localparam int WORD_W  = 16;
  // control word fields
  localparam int CT_CLEAR = 0;
  localparam int CT_SW_LO = 1;
  localparam int CT_OCP   = 13;
  localparam int CT_OVLE  = 15;
  // diagnosis word fields
  localparam int DG_TEMP   = 0;
  localparam int DG_SW_LO  = 1;
  localparam int DG_OVER   = 13;
  localparam int DG_UNDER  = 14;
  localparam int DG_SUPPLY = 15;
endpackage

// File: rtl/hb_persist_filter.sv
module hb_persist_filter #(
  parameter int DLY = 16,
  parameter int N   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] qual
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIM = CW'(DLY);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!raw[g])    cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
    assign qual[g] = (cnt == LIM);
  end
endmodule

// File: rtl/hb_ctrl_reg.sv
module hb_ctrl_reg
  import hb_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [NSW-1:0]    sw_req,
  output logic              ocp_en,
  output logic              ovle_en,
  output logic              clr
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[CT_OCP-1:CT_SW_LO+NSW], wr_data[CT_OVLE-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req  <= '0;
      ocp_en  <= 1'b0;
      ovle_en <= 1'b0;
    end else if (wr_en) begin
      sw_req  <= wr_data[CT_SW_LO +: NSW];
      ocp_en  <= wr_data[CT_OCP];
      ovle_en <= wr_data[CT_OVLE];
    end
  end

  assign clr = wr_en & wr_data[CT_CLEAR];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q | set;
  end
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hb_fault_pkg::*;
#(
  parameter int OC_DLY = 2800,
  parameter int UL_DLY = 37000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [NSW-1:0]      oc_raw,
  input  logic [NBRIDGE-1:0]  ul_raw,
  input  logic                uv_raw,
  input  logic                ov_raw,
  input  logic                tw_raw,
  input  logic                tsd_raw,
  output logic [NSW-1:0]      gate_en,
  output logic [WORD_W-1:0]   diag
);
  localparam int LW = NSW + 4;

  logic [NSW-1:0]     sw_req, oc_qual, oc_lat;
  logic [NBRIDGE-1:0] ul_qual;
  logic               ocp_en, ovle_en, clr;
  logic               uv_q, ov_q, tw_q, tsd_q;
  logic [LW-1:0]      lat_set, lat_q;
  logic               f_sup, f_ul, f_ol, f_tw, global_off;

  hb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sw_req(sw_req), .ocp_en(ocp_en), .ovle_en(ovle_en), .clr(clr)
  );

  hb_persist_filter #(.DLY(OC_DLY), .N(NSW)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .raw(oc_raw), .qual(oc_qual)
  );

  hb_persist_filter #(.DLY(UL_DLY), .N(NBRIDGE)) u_ul_filt (
    .clk(clk), .rst_n(rst_n), .raw(ul_raw), .qual(ul_qual)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q <= 1'b0; ov_q <= 1'b0; tw_q <= 1'b0; tsd_q <= 1'b0;
    end else begin
      uv_q <= uv_raw; ov_q <= ov_raw; tw_q <= tw_raw; tsd_q <= tsd_raw;
    end
  end

  assign lat_set = {oc_qual, uv_q | ov_q, |ul_qual, |oc_qual, tw_q};

  hb_fault_latch #(.W(LW)) u_latch (
    .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(clr), .q(lat_q)
  );

  assign oc_lat = lat_q[LW-1 -: NSW];
  assign f_sup  = lat_q[3];
  assign f_ul   = lat_q[2];
  assign f_ol   = lat_q[1];
  assign f_tw   = lat_q[0];

  assign global_off = uv_q | (ov_q & ovle_en) | tsd_q;
  assign gate_en    = sw_req & ~(oc_lat & {NSW{ocp_en}}) & {NSW{~global_off}};

  always_comb begin
    diag                     = '0;
    diag[DG_TEMP]            = f_tw;
    diag[DG_SW_LO +: NSW]    = gate_en;
    diag[DG_OVER]            = f_ol;
    diag[DG_UNDER]           = f_ul;
    diag[DG_SUPPLY]          = f_sup;
  end
endmodule

// File: rtl/hb_fault_supervisor_chk.sv
module hb_fault_supervisor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        uv_raw,
  input logic        tsd_raw,
  input logic [5:0]  gate_en,
  input logic [15:0] diag
);
  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_raw |=> (gate_en == 6'b0)); // R7
  AST_TSD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_raw |=> (gate_en == 6'b0)); // R10
  AST_GATE_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((gate_en & ~$past(wr_data[6:1])) == 6'b0)); // R2
  AST_SUPPLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (diag[15] && !(wr_en && wr_data[0])) |=> diag[15]); // R7
  AST_TEMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (diag[0] && !(wr_en && wr_data[0])) |=> diag[0]); // R6
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> (diag[15:13] == 3'b0 && !diag[0])); // R11
endmodule

bind hb_fault_supervisor hb_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .uv_raw(uv_raw), .tsd_raw(tsd_raw), .gate_en(gate_en), .diag(diag)
);

// File: tb/hb_fault_supervisor_bench.sv
module hb_fault_supervisor_bench;
  localparam int OC_D = 6;
  localparam int UL_D = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [5:0]  oc_raw = '0;
  logic [2:0]  ul_raw = '0;
  logic        uv_raw = 1'b0, ov_raw = 1'b0, tw_raw = 1'b0, tsd_raw = 1'b0;
  logic [5:0]  gate_en;
  logic [15:0] diag;

  int checks = 0;
  int errors = 0;

  // model state
  logic [5:0] m_sw, m_oclat;
  logic       m_ocp, m_ovle, m_uvq, m_ovq, m_twq, m_tsdq;
  logic       m_sup, m_ul, m_ol, m_tw;
  int         m_oc_cnt [6];
  int         m_ul_cnt [3];

  always #5 clk = ~clk;

  hb_fault_supervisor #(.OC_DLY(OC_D), .UL_DLY(UL_D)) u_hb_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .oc_raw(oc_raw), .ul_raw(ul_raw), .uv_raw(uv_raw), .ov_raw(ov_raw),
    .tw_raw(tw_raw), .tsd_raw(tsd_raw), .gate_en(gate_en), .diag(diag)
  );

  task automatic model_init();
    m_sw = '0; m_oclat = '0; m_ocp = 0; m_ovle = 0;
    m_uvq = 0; m_ovq = 0; m_twq = 0; m_tsdq = 0;
    m_sup = 0; m_ul = 0; m_ol = 0; m_tw = 0;
    for (int i = 0; i < 6; i++) m_oc_cnt[i] = 0;
    for (int i = 0; i < 3; i++) m_ul_cnt[i] = 0;
  endtask

  task automatic model_step();
    logic [5:0] qoc;
    logic [2:0] qul;
    for (int i = 0; i < 6; i++) qoc[i] = (m_oc_cnt[i] == OC_D);
    for (int i = 0; i < 3; i++) qul[i] = (m_ul_cnt[i] == UL_D);
    if (wr_en && wr_data[0]) begin
      m_oclat = '0; m_sup = 0; m_ul = 0; m_ol = 0; m_tw = 0;
    end else begin
      m_oclat = m_oclat | qoc;
      m_sup   = m_sup | m_uvq | m_ovq;
      m_ul    = m_ul | (|qul);
      m_ol    = m_ol | (|qoc);
      m_tw    = m_tw | m_twq;
    end
    for (int i = 0; i < 6; i++)
      m_oc_cnt[i] = !oc_raw[i] ? 0 : (m_oc_cnt[i] < OC_D ? m_oc_cnt[i] + 1 : OC_D);
    for (int i = 0; i < 3; i++)
      m_ul_cnt[i] = !ul_raw[i] ? 0 : (m_ul_cnt[i] < UL_D ? m_ul_cnt[i] + 1 : UL_D);
    m_uvq = uv_raw; m_ovq = ov_raw; m_twq = tw_raw; m_tsdq = tsd_raw;
    if (wr_en) begin
      m_sw = wr_data[6:1]; m_ocp = wr_data[13]; m_ovle = wr_data[15];
    end
  endtask

  function automatic logic [5:0] exp_gate();
    logic off;
    off = m_uvq | (m_ovq & m_ovle) | m_tsdq;
    return m_sw & ~(m_oclat & {6{m_ocp}}) & {6{~off}};
  endfunction

  function automatic logic [15:0] exp_diag();
    return {m_sup, m_ul, m_ol, 6'b0, exp_gate(), m_tw};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(string gtag);
    logic [15:0] d;
    d = exp_diag();
    chk(gtag, {10'b0, gate_en}, {10'b0, exp_gate()});
    chk("R9 diag switch status", {diag[12:1], 4'b0}, {d[12:1], 4'b0});
    chk("R7 diag supply", {15'b0, diag[15]}, {15'b0, d[15]});
    chk("R8 diag underload", {15'b0, diag[14]}, {15'b0, d[14]});
    chk("R5 diag overload", {15'b0, diag[13]}, {15'b0, d[13]});
    chk("R6 diag prewarning", {15'b0, diag[0]}, {15'b0, d[0]});
  endtask

  task automatic tick(string gtag, int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      wr_en = 1'b0;
      cmp(gtag);
    end
  endtask

  task automatic wr(logic [15:0] w, string gtag);
    wr_en = 1'b1; wr_data = w;
    tick(gtag);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    chk("R1 reset gate", {10'b0, gate_en}, 16'h0);
    chk("R1 reset diag", diag, 16'h0);
    rst_n = 1'b1;
    tick("R1", 1);
    // R2 request all switches with both protections on
    wr(16'hA07E, "R2");
    tick("R2", 3);
    chk("R2 all gates on", {10'b0, gate_en}, 16'h003F);
    // R3 short overcurrent run is forgotten
    oc_raw[2] = 1'b1; tick("R3", OC_D - 1); oc_raw[2] = 1'b0;
    tick("R3", 4);
    chk("R3 short run no effect", {10'b0, gate_en}, 16'h003F);
    // R3 qualified overcurrent on LS2 only
    oc_raw[2] = 1'b1; tick("R3", OC_D + 3); oc_raw[2] = 1'b0;
    tick("R3", 3);
    chk("R3 selective cut", {10'b0, gate_en}, 16'h003B);
    // R11 clear releases cut
    wr(16'hA07F, "R11"); tick("R11", 2);
    chk("R11 cut released", {10'b0, gate_en}, 16'h003F);
    // R11 persisting fault re-latches after clear
    oc_raw[5] = 1'b1; tick("R11", OC_D + 2);
    wr(16'hA07F, "R11");
    chk("R11 one-cycle release", {10'b0, gate_en}, 16'h003F);
    tick("R11", 1);
    chk("R11 re-latched", {10'b0, gate_en}, 16'h001F);
    oc_raw[5] = 1'b0; wr(16'hA07F, "R11"); tick("R11", 2);
    // R4 overcurrent reaction masked
    wr(16'h807F, "R4");
    oc_raw[0] = 1'b1; tick("R4", OC_D + 4); oc_raw[0] = 1'b0;
    tick("R4", 2);
    chk("R4 no cut when masked", {10'b0, gate_en}, 16'h003F);
    chk("R5 overload flagged", {15'b0, diag[13]}, 16'h1);
    // R6 prewarning
    tw_raw = 1'b1; tick("R6"); tw_raw = 1'b0; tick("R6", 3);
    chk("R6 gates unaffected", {10'b0, gate_en}, 16'h003F);
    // R7 undervoltage and recovery
    wr(16'hA07F, "R7");
    uv_raw = 1'b1; tick("R7", 5); uv_raw = 1'b0; tick("R7", 3);
    chk("R7 resume after uv", {10'b0, gate_en}, 16'h003F);
    ov_raw = 1'b1; tick("R7", 4);
    chk("R7 ov lockout", {10'b0, gate_en}, 16'h0);
    ov_raw = 1'b0; tick("R7", 2);
    wr(16'h007F, "R7");
    ov_raw = 1'b1; tick("R7", 4);
    chk("R7 ov masked", {10'b0, gate_en}, 16'h003F);
    ov_raw = 1'b0; tick("R7", 2);
    // R10 thermal shutdown
    tsd_raw = 1'b1; tick("R10", 4);
    chk("R10 all off", {10'b0, gate_en}, 16'h0);
    tsd_raw = 1'b0; tick("R10", 2);
    // R8 underload
    wr(16'hA07F, "R8");
    ul_raw[1] = 1'b1; tick("R8", UL_D - 2); ul_raw[1] = 1'b0; tick("R8", 3);
    chk("R8 short run ignored", {15'b0, diag[14]}, 16'h0);
    ul_raw[1] = 1'b1; tick("R8", UL_D + 2); ul_raw[1] = 1'b0; tick("R8", 2);
    chk("R8 underload set", {15'b0, diag[14]}, 16'h1);
    // R11 clear while undervoltage held
    uv_raw = 1'b1; tick("R11", 3);
    wr(16'hA07F, "R11");
    chk("R11 supply cleared", {15'b0, diag[15]}, 16'h0);
    tick("R11", 1);
    chk("R11 supply re-set", {15'b0, diag[15]}, 16'h1);
    uv_raw = 1'b0; tick("R11", 2);
    // random phase
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 6; i++) if ($urandom_range(0, 19) == 0) oc_raw[i] = ~oc_raw[i];
      for (int i = 0; i < 3; i++) if ($urandom_range(0, 24) == 0) ul_raw[i] = ~ul_raw[i];
      if ($urandom_range(0, 59) == 0) uv_raw = ~uv_raw;
      if ($urandom_range(0, 59) == 0) ov_raw = ~ov_raw;
      if ($urandom_range(0, 39) == 0) tw_raw = ~tw_raw;
      if ($urandom_range(0, 79) == 0) tsd_raw = ~tsd_raw;
      if ($urandom_range(0, 29) == 0) begin
        wr_en = 1'b1; wr_data = 16'($urandom);
      end
      tick("R3 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule